// File: doc/BRIEF.md
# Prescaled Multi-Channel PWM Timer

This block generates several pulse-width-modulated outputs from one shared time base. A prescale counter slows the incoming clock by a programmable factor. Each slowed tick advances a period counter that climbs from zero to a programmable reload value and then returns to zero. Every output channel compares that counter with its own compare value. A per-channel polarity selects whether the output is high below the compare value or at and above it.

Software programs the block through a plain write port with an address, a data word and a strobe. New settings go into pending copies first. The running copies pick them up at the end of the current period, so a period is never cut short or distorted. While the enable input is low, the counters rest at zero, the outputs stay low, and pending settings pass straight into the running copies. When the enable input rises, counting starts from a clean period.

The frequency of each output is the clock divided by (prescale + 1) × (reload + 1). The duty of a channel is compare / (reload + 1) in the below-compare polarity. In the other polarity it is the complement of that value.

Top module: `pwm_timer`

## Requirements
- R1: While enabled, the period counter holds each value for exactly (prescale + 1) clock cycles, so a prescale of 0 advances it on every cycle.
- R2: The period counter runs 0, 1, ..., reload and then returns to 0, so one output period lasts (prescale + 1) × (reload + 1) clock cycles.
- R3: A channel whose mode bit is 0 drives its output high exactly while the period counter is below its compare value. Its high time per period is compare × (prescale + 1) cycles.
- R4: A channel whose mode bit is 1 drives its output high exactly while the period counter is at or above its compare value. This is the complement of mode 0.
- R5: With mode 0, a compare value of 0 keeps the output low for the whole period, and a compare value above reload keeps it high for the whole period. With mode 1, a compare value of 0 keeps the output high.
- R6: All channels share one counter and one period. Each channel uses only its own compare value and its own mode bit.
- R7: While enabled, a written setting (prescale, reload, compare or mode) takes effect only at the clock edge where the counter wraps from reload to 0. The period in progress finishes with the old settings.
- R8: While the enable input is low, the prescale counter and the period counter are held at 0 and every output is low. On re-enable, counting starts at 0. Settings written while disabled are in force by the time the enable input rises, provided one clock cycle has passed since the write.
- R9: Register addresses: 0 holds the prescale value, 1 holds the reload value, and 2 holds the mode bits, with bit i selecting the mode of channel i. Address 3 + i holds the compare value of channel i. A write takes place on a rising clock edge with wr_en high.
- R10: After the asynchronous active-low reset, all settings are 0 and the outputs are low.
- R11: With 16-bit registers, prescale 89, reload 399 and compares of 120 and 300 in mode 0 give a 36000-cycle period. The two channels are high for 10800 and 27000 cycles of that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low holds the counters and forces the outputs low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W = ceil(log2(NUM_CH+3)) | Register address |
| wr_data | input | CNT_W | Register write data |
| pwm_out | output | NUM_CH | PWM outputs, bit i for channel i |

## Verification
The main instance is built with CNT_W = 4 and NUM_CH = 2. This makes it practical to sweep every prescale from 0 to 2 against every reload from 0 to 5 and every compare from 0 to 7. In each configuration one channel runs in each mode with different compare values, so both polarities, the empty and full duty cases and cycle-exact period lengths are all covered. A second instance keeps the default 16-bit width and runs the full 36000-cycle example period. Directed sequences cover a mid-period rewrite of the compare and reload values, and a disable and restart part-way through a period.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  typedef enum logic {
    CMP_BELOW_HIGH = 1'b0,
    CMP_ABOVE_HIGH = 1'b1
  } cmp_mode_e;

  localparam int REG_PRESCALE = 0;
  localparam int REG_RELOAD   = 1;
  localparam int REG_MODE     = 2;
  localparam int REG_CMP_BASE = 3;

  function automatic int reg_slots(input int num_ch);
    return REG_CMP_BASE + num_ch;
  endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] div,
  output logic             tick
);

  logic [CNT_W-1:0] pcnt;

  assign tick = run && (pcnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= '0;
    else if (!run)   pcnt <= '0;
    else if (tick)   pcnt <= '0;
    else             pcnt <= pcnt + 1'b1;
  end

endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  assign wrap = tick && (cnt == reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (wrap)  cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  input  logic                          run,
  input  logic                          wrap,
  output logic [CNT_W-1:0]              act_div,
  output logic [CNT_W-1:0]              act_reload,
  output logic [NUM_CH-1:0][CNT_W-1:0]  act_cmp,
  output logic [NUM_CH-1:0]             act_mode
);

  logic [CNT_W-1:0]             pend_div;
  logic [CNT_W-1:0]             pend_reload;
  logic [NUM_CH-1:0][CNT_W-1:0] pend_cmp;
  logic [NUM_CH-1:0]            pend_mode;
  logic                         load;

  // running copies follow the pending ones at a wrap or while idle
  assign load = wrap || !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_div    <= '0;
      pend_reload <= '0;
      pend_mode   <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(REG_PRESCALE)) pend_div    <= wr_data;
      if (wr_addr == ADDR_W'(REG_RELOAD))   pend_reload <= wr_data;
      if (wr_addr == ADDR_W'(REG_MODE))     pend_mode   <= wr_data[NUM_CH-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend_cmp[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(REG_CMP_BASE + i))
        pend_cmp[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div    <= '0;
      act_reload <= '0;
      act_cmp    <= '0;
      act_mode   <= '0;
    end else if (load) begin
      act_div    <= pend_div;
      act_reload <= pend_reload;
      act_cmp    <= pend_cmp;
      act_mode   <= pend_mode;
    end
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  cmp_mode_e        mode,
  output logic             out
);

  function automatic logic level(input logic [CNT_W-1:0] c,
                                 input logic [CNT_W-1:0] thr,
                                 input cmp_mode_e m);
    logic below;
    below = (c < thr);
    return (m == CMP_BELOW_HIGH) ? below : !below;
  endfunction

  assign out = run && level(cnt, cmp, mode);

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_tmr_pkg::*;
#(
  parameter  int CNT_W  = 16,
  parameter  int NUM_CH = 2,
  localparam int ADDR_W = $clog2(reg_slots(NUM_CH))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] pwm_out
);

  logic                         tick;
  logic                         wrap;
  logic [CNT_W-1:0]             cnt;
  logic [CNT_W-1:0]             act_div;
  logic [CNT_W-1:0]             act_reload;
  logic [NUM_CH-1:0][CNT_W-1:0] act_cmp;
  logic [NUM_CH-1:0]            act_mode;

  pwm_cfg_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run(en), .wrap(wrap), .act_div(act_div),
    .act_reload(act_reload), .act_cmp(act_cmp), .act_mode(act_mode)
  );

  pwm_tick_gen #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(en), .div(act_div), .tick(tick)
  );

  pwm_period_cnt #(.CNT_W(CNT_W)) u_period (
    .clk(clk), .rst_n(rst_n), .run(en), .tick(tick),
    .reload(act_reload), .cnt(cnt), .wrap(wrap)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .run(en), .cnt(cnt), .cmp(act_cmp[i]),
      .mode(cmp_mode_e'(act_mode[i])), .out(pwm_out[i])
    );
  end

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         run,
  input logic                         tick,
  input logic                         wrap,
  input logic [CNT_W-1:0]             cnt,
  input logic [CNT_W-1:0]             act_div,
  input logic [CNT_W-1:0]             act_reload,
  input logic [NUM_CH-1:0][CNT_W-1:0] act_cmp,
  input logic [NUM_CH-1:0]            act_mode,
  input logic [NUM_CH-1:0]            pwm_out
);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> (cnt == $past(cnt) + 1'b1));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  assert_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(act_div) && $stable(act_reload) &&
                        $stable(act_cmp) && $stable(act_mode)));

  assert_idle_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  assert_idle_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_out == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assert_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !act_mode[i] && act_cmp[i] == '0) |-> !pwm_out[i]);

    assert_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !act_mode[i] && act_cmp[i] > act_reload) |-> pwm_out[i]);

    assert_mode1_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && act_mode[i] && act_cmp[i] == '0) |-> pwm_out[i]);
  end

endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(en), .tick(tick), .wrap(wrap), .cnt(cnt),
  .act_div(act_div), .act_reload(act_reload), .act_cmp(act_cmp),
  .act_mode(act_mode), .pwm_out(pwm_out)
);

// File: tb/pwm_timer_bench.sv
module pwm_timer_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // small instance: 4-bit registers, two channels, 3-bit address
  logic       s_en = 1'b0, s_wr_en = 1'b0;
  logic [2:0] s_wr_addr = '0;
  logic [3:0] s_wr_data = '0;
  logic [1:0] s_out;

  // default-width instance
  logic        w_en = 1'b0, w_wr_en = 1'b0;
  logic [2:0]  w_wr_addr = '0;
  logic [15:0] w_wr_data = '0;
  logic [1:0]  w_out;

  pwm_timer #(.CNT_W(4), .NUM_CH(2)) u_pwm_timer (
    .clk(clk), .rst_n(rst_n), .en(s_en), .wr_en(s_wr_en),
    .wr_addr(s_wr_addr), .wr_data(s_wr_data), .pwm_out(s_out)
  );

  pwm_timer u_pwm_timer_wide (
    .clk(clk), .rst_n(rst_n), .en(w_en), .wr_en(w_wr_en),
    .wr_addr(w_wr_addr), .wr_data(w_wr_data), .pwm_out(w_out)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic s_write(input int a, input int d);
    s_wr_addr = 3'(a);
    s_wr_data = 4'(d);
    s_wr_en   = 1'b1;
    @(negedge clk);
    s_wr_en   = 1'b0;
  endtask

  task automatic w_write(input int a, input int d);
    w_wr_addr = 3'(a);
    w_wr_data = 16'(d);
    w_wr_en   = 1'b1;
    @(negedge clk);
    w_wr_en   = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk(s_out == 2'b00, "R10 outputs in reset", int'(s_out), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: all settings zero -> both mode-0 channels with compare 0 stay low
    s_en = 1'b1;
    #1;
    for (int k = 0; k < 4; k++) begin
      chk(s_out == 2'b00, "R10 reset settings", int'(s_out), 0);
      @(negedge clk); #1;
    end
    s_en = 1'b0;
    @(negedge clk);

    // Sweep: R1 R2 R3 R4 R5 R6 R8 R9
    for (int p = 0; p < 3; p++) begin
      for (int a = 0; a < 6; a++) begin
        for (int c = 0; c < 8; c++) begin
          int c1, per, mism, hi0, hi1, exp_hi0, exp_hi1, v, cm;
          bit e0, e1;
          c1 = (c + 3) % 8;
          per = (p + 1) * (a + 1);
          cm = (c < a + 1) ? c : a + 1;
          exp_hi0 = cm * (p + 1);
          cm = (c1 < a + 1) ? c1 : a + 1;
          exp_hi1 = per - cm * (p + 1);
          mism = 0; hi0 = 0; hi1 = 0;
          s_en = 1'b0;
          @(negedge clk);
          s_write(0, p);
          s_write(1, a);
          s_write(2, 2);      // channel 1 in mode 1
          s_write(3, c);
          s_write(4, c1);
          @(negedge clk);
          s_en = 1'b1;
          #1;
          for (int k = 0; k <= per; k++) begin
            v  = (k % per) / (p + 1);
            e0 = (v < c);
            e1 = !(v < c1);
            if (s_out[0] !== e0 || s_out[1] !== e1) mism++;
            if (k < per) begin
              if (s_out[0]) hi0++;
              if (s_out[1]) hi1++;
            end
            @(negedge clk); #1;
          end
          chk(mism == 0, "R1 R2 R3 R4 R6 cycle pattern", mism, 0);
          chk(hi0 == exp_hi0, "R3 R5 mode0 high cycles", hi0, exp_hi0);
          chk(hi1 == exp_hi1, "R4 mode1 high cycles", hi1, exp_hi1);
        end
      end
    end

    // R8: disable mid-period (last config: prescale 2, reload 5, cmp 7 / 2)
    s_en = 1'b0;
    #1;
    chk(s_out == 2'b00, "R8 outputs low when disabled", int'(s_out), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(s_out == 2'b00, "R8 outputs held low", int'(s_out), 0);
    end
    s_en = 1'b1;
    #1;
    chk(s_out == 2'b01, "R8 restart at count 0", int'(s_out), 1);
    repeat (5) @(negedge clk);
    #1;
    chk(s_out[1] == 1'b0, "R8 R1 count 1 after restart", int'(s_out[1]), 0);
    @(negedge clk); #1;
    chk(s_out[1] == 1'b1, "R8 R1 count 2 after restart", int'(s_out[1]), 1);

    // R7: mid-period rewrite of compare and reload
    s_en = 1'b0;
    @(negedge clk);
    s_write(0, 0);
    s_write(1, 3);
    s_write(2, 0);
    s_write(3, 2);
    s_write(4, 0);
    @(negedge clk);
    s_en = 1'b1;
    #1;
    chk(s_out[0] == 1'b1, "R7 start of period", int'(s_out[0]), 1);
    s_write(3, 4);
    s_write(1, 5);
    #1;
    chk(s_out[0] == 1'b0, "R7 old compare kept at count 2", int'(s_out[0]), 0);
    @(negedge clk); #1;
    chk(s_out[0] == 1'b0, "R7 old compare kept at count 3", int'(s_out[0]), 0);
    @(negedge clk); #1;
    begin
      int mism;
      mism = 0;
      for (int k = 0; k <= 6; k++) begin
        if (s_out[0] !== ((k % 6) < 4)) mism++;
        @(negedge clk); #1;
      end
      chk(mism == 0, "R7 new settings after wrap", mism, 0);
    end
    s_en = 1'b0;

    // R11: default-width example
    w_write(0, 89);
    w_write(1, 399);
    w_write(2, 0);
    w_write(3, 120);
    w_write(4, 300);
    @(negedge clk);
    w_en = 1'b1;
    #1;
    begin
      int hi0, hi1, last0;
      hi0 = 0; hi1 = 0; last0 = 0;
      for (int k = 0; k < 36000; k++) begin
        if (w_out[0]) hi0++;
        if (w_out[1]) hi1++;
        last0 = int'(w_out[1]);
        @(negedge clk); #1;
      end
      chk(hi0 == 10800, "R11 channel 0 high cycles", hi0, 10800);
      chk(hi1 == 27000, "R11 channel 1 high cycles", hi1, 27000);
      chk(last0 == 0, "R11 end of period low", last0, 0);
      chk(w_out == 2'b11, "R11 R2 next period starts high", int'(w_out), 3);
    end
    w_en = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule